// File: doc/BRIEF.md
# Packed Vector Arithmetic Right Shifter

This block takes a vector of up to 512 bits, treats it as packed signed elements of 16, 32 or 64 bits, and shifts every element right by one common count while copying the element's sign bit into the vacated high-order positions. The count comes either from an 8-bit immediate or from the low half of a 128-bit count operand. Counts beyond the element width saturate to a full sign fill.

Lane-level write control is applied after the shift. Each lane either takes the shifted value, keeps the old destination value (merge), or becomes zero (zeroing). Bits beyond the selected vector length are cleared. An optional broadcast repeats the lowest source element into every lane. A legacy mode confines the write to the low 128 bits and passes the old destination through above them.

The result is registered. A two-state output sequencer tracks whether the held result is fresh:
- ST_IDLE moves to ST_VALID on `in_valid` (the accept transition).
- ST_VALID stays in ST_VALID while `in_valid` remains high.
- ST_VALID returns to ST_IDLE when `in_valid` is low (the drain transition).

Top module: `simd_sar_unit`

## Requirements
- R1: Each element shifts right by the count, independently of its neighbours, with the vacated upper bits filled by that element's original sign bit. The element size is chosen by `elem_sel`: 00 gives 16 bits, 01 gives 32 bits, and 10 or 11 give 64 bits. Element j occupies bits j*W upward from bit 0.
- R2: A count above 15 (16-bit elements), above 31 (32-bit elements) or above 63 (64-bit elements) makes every bit of the element equal to its sign bit.
- R3: With `use_imm` low, the count is `cnt_vec[63:0]` taken as one 64-bit unsigned value, so a set bit anywhere in it counts toward saturation. `cnt_vec[127:64]` has no effect on the result.
- R4: With `use_imm` high, the count is `imm_cnt` zero-extended to 64 bits, and `cnt_vec` has no effect.
- R5: Lane j is controlled by `mask[j]`. A lane is written with the shifted value when `mask_en` is low or `mask[j]` is 1. Otherwise it keeps `old_dst` when `zero_mode` is 0, and becomes zero when `zero_mode` is 1. Mask bits at or above the lane count are ignored.
- R6: `vlen_sel` 00 selects 128 bits, 01 selects 256 bits, and 10 or 11 select 512 bits. Result bits above the selected length are zero.
- R7: When `bcast` and `use_imm` are both high and the element size is 32 or 64 bits, element 0 of `src_vec` is shifted and placed in every lane. For 16-bit elements, or with a register count, `bcast` has no effect.
- R8: When `legacy` is high, bits 127:0 take the shifted elements with masking and broadcast ignored, and bits 511:128 equal `old_dst[511:128]`.
- R9: `out_valid` equals `in_valid` delayed by one clock. `result` loads on each clock where `in_valid` is high and holds otherwise. Reset clears both `result` and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| src_vec | input | 512 | Vector to be shifted |
| old_dst | input | 512 | Previous destination value for merge and legacy |
| imm_cnt | input | 8 | Immediate count |
| cnt_vec | input | 128 | Register count operand, low 64 bits used |
| use_imm | input | 1 | 1 selects the immediate count |
| elem_sel | input | 2 | Element size code |
| vlen_sel | input | 2 | Vector length code |
| mask | input | 32 | Per-lane write mask |
| mask_en | input | 1 | 1 enables lane masking |
| zero_mode | input | 1 | 1 zeroes masked lanes, 0 merges |
| bcast | input | 1 | Broadcast element 0 |
| legacy | input | 1 | 128-bit write with upper destination preserved |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 512 | Registered shifted vector |

## Verification
Saturation and masking regularly meet in the same operation. A masked-off lane must show the old destination or zero even when its unmasked neighbours are fully sign-filled by an oversized count. The bench drives random masks together with counts drawn around each width boundary and with high bits set in the 64-bit count, and checks every lane against a bit-level behavioural model.

Broadcast with a zeroing mask and a shortened vector length is provoked in the same way. Every clock compares both `out_valid` and `result` with the model, so idle cycles in which the result must hold are judged too.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam logic [1:0] ESZ_16 = 2'b00;
    localparam logic [1:0] ESZ_32 = 2'b01;

    localparam logic [1:0] VL_QUARTER = 2'b00;
    localparam logic [1:0] VL_HALF    = 2'b01;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;
endpackage

// File: rtl/sar_count_unit.sv
module sar_count_unit #(
    parameter int IMM_W = 8
) (
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm_cnt,
    input  logic [63:0]      cnt_lo,
    output logic [3:0]       amt16,
    output logic [4:0]       amt32,
    output logic [5:0]       amt64
);
    localparam int PAD_W = 64 - IMM_W;

    logic [63:0] cnt_full;

    always_comb begin
        if (use_imm) begin
            cnt_full = {{PAD_W{1'b0}}, imm_cnt};
        end else begin
            cnt_full = cnt_lo;
        end
    end

    // Shifting by width-1 already yields a full sign fill.
    always_comb begin
        amt16 = (cnt_full > 64'd15) ? 4'd15 : cnt_full[3:0];
        amt32 = (cnt_full > 64'd31) ? 5'd31 : cnt_full[4:0];
        amt64 = (cnt_full > 64'd63) ? 6'd63 : cnt_full[5:0];
    end
endmodule

// File: rtl/sar_lane_bank.sv
module sar_lane_bank #(
    parameter int VEC_W  = 512,
    parameter int ELEM_W = 32
) (
    input  logic [VEC_W-1:0]          src,
    input  logic [$clog2(ELEM_W)-1:0] amt,
    output logic [VEC_W-1:0]          shifted
);
    localparam int LANES = VEC_W / ELEM_W;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic signed [ELEM_W-1:0] elem;
            assign elem = src[l*ELEM_W +: ELEM_W];
            assign shifted[l*ELEM_W +: ELEM_W] = elem >>> amt;
        end
    endgenerate
endmodule

// File: rtl/sar_lane_select.sv
module sar_lane_select
    import sar_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic [1:0]         elem_sel,
    input  logic [1:0]         vlen_sel,
    input  logic               legacy,
    input  logic               mask_en,
    input  logic               zero_mode,
    input  logic [VEC_W/16-1:0] mask,
    input  logic [VEC_W-1:0]   old_dst,
    input  logic [VEC_W-1:0]   sh16,
    input  logic [VEC_W-1:0]   sh32,
    input  logic [VEC_W-1:0]   sh64,
    output logic [VEC_W-1:0]   result_d
);
    localparam int NG    = VEC_W / 16;
    localparam int LIM_W = $clog2(NG) + 1;

    logic [LIM_W-1:0] gran_lim;
    logic [VEC_W-1:0] bank;

    always_comb begin
        if (legacy) begin
            gran_lim = LIM_W'(NG / 4);
        end else begin
            unique case (vlen_sel)
                VL_QUARTER: gran_lim = LIM_W'(NG / 4);
                VL_HALF:    gran_lim = LIM_W'(NG / 2);
                default:    gran_lim = LIM_W'(NG);
            endcase
        end
    end

    always_comb begin
        unique case (elem_sel)
            ESZ_16:  bank = sh16;
            ESZ_32:  bank = sh32;
            default: bank = sh64;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NG; g++) begin : g_gran
            logic lane_bit;
            logic in_len;
            logic wr_en;

            always_comb begin
                unique case (elem_sel)
                    ESZ_16:  lane_bit = mask[g];
                    ESZ_32:  lane_bit = mask[g/2];
                    default: lane_bit = mask[g/4];
                endcase
            end

            assign in_len = (LIM_W'(g) < gran_lim);
            assign wr_en  = legacy | ~mask_en | lane_bit;

            always_comb begin
                if (!in_len) begin
                    result_d[g*16 +: 16] = legacy ? old_dst[g*16 +: 16] : 16'h0;
                end else if (wr_en) begin
                    result_d[g*16 +: 16] = bank[g*16 +: 16];
                end else if (zero_mode) begin
                    result_d[g*16 +: 16] = 16'h0;
                end else begin
                    result_d[g*16 +: 16] = old_dst[g*16 +: 16];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/simd_sar_unit.sv
module simd_sar_unit
    import sar_pkg::*;
#(
    parameter int VEC_W = 512,
    parameter int CNT_W = 128,
    parameter int IMM_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   old_dst,
    input  logic [IMM_W-1:0]   imm_cnt,
    input  logic [CNT_W-1:0]   cnt_vec,
    input  logic               use_imm,
    input  logic [1:0]         elem_sel,
    input  logic [1:0]         vlen_sel,
    input  logic [VEC_W/16-1:0] mask,
    input  logic               mask_en,
    input  logic               zero_mode,
    input  logic               bcast,
    input  logic               legacy,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result
);
    localparam int L32 = VEC_W / 32;
    localparam int L64 = VEC_W / 64;

    logic [CNT_W-65:0] unused_cnt_hi;
    assign unused_cnt_hi = cnt_vec[CNT_W-1:64];

    logic bc_on;
    logic [VEC_W-1:0] src32;
    logic [VEC_W-1:0] src64;
    logic [3:0] amt16;
    logic [4:0] amt32;
    logic [5:0] amt64;
    logic [VEC_W-1:0] sh16;
    logic [VEC_W-1:0] sh32;
    logic [VEC_W-1:0] sh64;
    logic [VEC_W-1:0] result_d;

    assign bc_on = bcast & use_imm & ~legacy & (elem_sel != ESZ_16);
    assign src32 = bc_on ? {L32{src_vec[31:0]}} : src_vec;
    assign src64 = bc_on ? {L64{src_vec[63:0]}} : src_vec;

    sar_count_unit #(.IMM_W(IMM_W)) u_cnt (
        .use_imm (use_imm),
        .imm_cnt (imm_cnt),
        .cnt_lo  (cnt_vec[63:0]),
        .amt16   (amt16),
        .amt32   (amt32),
        .amt64   (amt64)
    );

    sar_lane_bank #(.VEC_W(VEC_W), .ELEM_W(16)) u_bank16 (
        .src(src_vec), .amt(amt16), .shifted(sh16)
    );
    sar_lane_bank #(.VEC_W(VEC_W), .ELEM_W(32)) u_bank32 (
        .src(src32), .amt(amt32), .shifted(sh32)
    );
    sar_lane_bank #(.VEC_W(VEC_W), .ELEM_W(64)) u_bank64 (
        .src(src64), .amt(amt64), .shifted(sh64)
    );

    sar_lane_select #(.VEC_W(VEC_W)) u_sel (
        .elem_sel  (elem_sel),
        .vlen_sel  (vlen_sel),
        .legacy    (legacy),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .mask      (mask),
        .old_dst   (old_dst),
        .sh16      (sh16),
        .sh32      (sh32),
        .sh64      (sh64),
        .result_d  (result_d)
    );

    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= result_d;
        end
    end

    assign out_valid = (state_q == ST_VALID);
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
    parameter int VEC_W = 512,
    parameter int IMM_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [VEC_W-1:0]   src_vec,
    input logic [VEC_W-1:0]   old_dst,
    input logic [IMM_W-1:0]   imm_cnt,
    input logic [63:0]        cnt_lo,
    input logic               use_imm,
    input logic [1:0]         elem_sel,
    input logic [1:0]         vlen_sel,
    input logic [VEC_W/16-1:0] mask,
    input logic               mask_en,
    input logic               zero_mode,
    input logic               bcast,
    input logic               legacy,
    input logic               out_valid,
    input logic [VEC_W-1:0]   result
);
    localparam int QTR = VEC_W / 4;

    logic big64;
    assign big64 = use_imm ? (imm_cnt > IMM_W'(63)) : (cnt_lo > 64'd63);

    a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legacy && vlen_sel == 2'b00) |=> (result[VEC_W-1:QTR] == '0));

    a_r8_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legacy) |=> (result[VEC_W-1:QTR] == $past(old_dst[VEC_W-1:QTR])));

    a_r5_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legacy && mask_en && zero_mode && mask == '0) |=> (result == '0));

    a_r5_merge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legacy && mask_en && !zero_mode && mask == '0 && vlen_sel[1])
        |=> (result == $past(old_dst)));

    a_r2_sat_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legacy && !mask_en && elem_sel[1] && big64)
        |=> (result[63:0] == {64{$past(src_vec[63])}}));

    a_r7_bcast_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bcast && use_imm && !legacy && !mask_en && elem_sel[1])
        |=> (result[127:64] == result[63:0]));
endmodule

bind simd_sar_unit sar_checker #(.VEC_W(VEC_W), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .old_dst(old_dst), .imm_cnt(imm_cnt), .cnt_lo(cnt_vec[63:0]),
    .use_imm(use_imm), .elem_sel(elem_sel), .vlen_sel(vlen_sel),
    .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
    .legacy(legacy), .out_valid(out_valid), .result(result)
);

// File: tb/sim_simd_sar_unit.sv
`timescale 1ns/1ps
module sim_simd_sar_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   imm_cnt = '0;
    logic [127:0] cnt_vec = '0;
    logic         use_imm = 1'b0;
    logic [1:0]   elem_sel = '0;
    logic [1:0]   vlen_sel = '0;
    logic [31:0]  mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast = 1'b0;
    logic         legacy = 1'b0;
    logic         out_valid;
    logic [511:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit checking = 0;
    bit done = 0;
    string cur_tag = "R9 idle";
    string exp_tag = "R9 reset";
    logic exp_v = 1'b0;
    logic [511:0] exp_r = '0;

    always #4 clk = ~clk;

    simd_sar_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .imm_cnt(imm_cnt), .cnt_vec(cnt_vec),
        .use_imm(use_imm), .elem_sel(elem_sel), .vlen_sel(vlen_sel),
        .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
        .legacy(legacy), .out_valid(out_valid), .result(result)
    );

    function automatic logic [511:0] ref_calc();
        int w, vl, base;
        longint unsigned c;
        logic [511:0] r;
        logic sgn, act;
        w  = (elem_sel == 2'b00) ? 16 : (elem_sel == 2'b01) ? 32 : 64;
        vl = legacy ? 128 : (vlen_sel == 2'b00) ? 128 : (vlen_sel == 2'b01) ? 256 : 512;
        c  = use_imm ? longint'(imm_cnt) : cnt_vec[63:0];
        r  = legacy ? {old_dst[511:128], 128'b0} : '0;
        for (int j = 0; j < vl / w; j++) begin
            act  = legacy || !mask_en || mask[j];
            base = (bcast && use_imm && w != 16 && !legacy) ? 0 : j * w;
            sgn  = src_vec[base + w - 1];
            for (int b = 0; b < w; b++) begin
                if (!act) r[j*w + b] = zero_mode ? 1'b0 : old_dst[j*w + b];
                else if (c >= longint'(w - b)) r[j*w + b] = sgn;
                else r[j*w + b] = src_vec[base + b + int'(c)];
            end
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_v <= 1'b0;
            exp_r <= '0;
            exp_tag <= "R9 reset";
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                exp_r <= ref_calc();
                exp_tag <= cur_tag;
            end else begin
                exp_tag <= "R9 hold";
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            n_checks++;
            if (out_valid !== exp_v || result !== exp_r) begin
                n_fail++;
                $display("FAIL %s: out_valid %0b exp %0b result %h exp %h",
                         exp_tag, out_valid, exp_v, result, exp_r);
            end
        end
    end

    task automatic new_data();
        for (int k = 0; k < 16; k++) begin
            src_vec[k*32 +: 32] = $urandom;
            old_dst[k*32 +: 32] = $urandom;
        end
    endtask

    task automatic op(input string tag, input logic [1:0] es, input logic [1:0] vl,
                      input logic ui, input logic [7:0] im, input logic [127:0] cv,
                      input logic me, input logic zm, input logic [31:0] mk,
                      input logic bc, input logic lg);
        new_data();
        elem_sel = es; vlen_sel = vl; use_imm = ui; imm_cnt = im; cnt_vec = cv;
        mask_en = me; zero_mode = zm; mask = mk; bcast = bc; legacy = lg;
        in_valid = 1'b1; cur_tag = tag;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        cur_tag = "R9 idle";
        for (int k = 0; k < n; k++) begin
            src_vec = ~src_vec;
            old_dst = ~old_dst;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            n_fail++;
            $display("FAIL R9 reset: out_valid %0b exp 0 result %h exp 0", out_valid, result);
        end
        rst_n = 1'b1;
        checking = 1;
        @(negedge clk);

        op("R1 16b imm 3",   2'b00, 2'b00, 1, 8'd3,   '0, 0, 0, '0, 0, 0);
        op("R1 32b reg 5",   2'b01, 2'b01, 0, 8'd0,   128'd5, 0, 0, '0, 0, 0);
        op("R1 64b imm 17",  2'b10, 2'b10, 1, 8'd17,  '0, 0, 0, '0, 0, 0);
        op("R2 16b cnt 15",  2'b00, 2'b10, 0, 8'd0,   128'd15, 0, 0, '0, 0, 0);
        op("R2 16b cnt 16",  2'b00, 2'b10, 0, 8'd0,   128'd16, 0, 0, '0, 0, 0);
        op("R2 32b cnt 32",  2'b01, 2'b10, 0, 8'd0,   128'd32, 0, 0, '0, 0, 0);
        op("R2 64b imm 200", 2'b11, 2'b10, 1, 8'd200, '0, 0, 0, '0, 0, 0);
        op("R3 upper ignored", 2'b01, 2'b10, 0, 8'd0, {64'hFFFF_FFFF_FFFF_FFFF, 64'd4}, 0, 0, '0, 0, 0);
        op("R3 bit40 saturates", 2'b00, 2'b10, 0, 8'd0, {64'h0, 64'h0000_0100_0000_0002}, 0, 0, '0, 0, 0);
        op("R4 imm 255",     2'b01, 2'b10, 1, 8'hFF,  128'd1, 0, 0, '0, 0, 0);
        op("R4 cnt_vec ignored", 2'b00, 2'b10, 1, 8'd2, 128'd9, 0, 0, '0, 0, 0);
        op("R5 merge",       2'b00, 2'b10, 1, 8'd4,   '0, 1, 0, 32'hA5C3_0F71, 0, 0);
        op("R5 zeroing",     2'b01, 2'b10, 1, 8'd4,   '0, 1, 1, 32'hFFFF_3A5C, 0, 0);
        op("R5 mask off",    2'b10, 2'b10, 1, 8'd1,   '0, 0, 1, 32'h0, 0, 0);
        op("R5 high mask bits ignored", 2'b10, 2'b10, 1, 8'd1, '0, 1, 1, 32'hFFFF_FF00, 0, 0);
        op("R6 len 128",     2'b00, 2'b00, 1, 8'd1,   '0, 0, 0, '0, 0, 0);
        op("R6 len 256",     2'b10, 2'b01, 1, 8'd9,   '0, 0, 0, '0, 0, 0);
        op("R7 bcast 32",    2'b01, 2'b10, 1, 8'd7,   '0, 0, 0, '0, 1, 0);
        op("R7 bcast 64 zero mask", 2'b10, 2'b01, 1, 8'd70, '0, 1, 1, 32'h5, 1, 0);
        op("R7 bcast 16 ignored", 2'b00, 2'b10, 1, 8'd3, '0, 0, 0, '0, 1, 0);
        op("R7 bcast reg ignored", 2'b01, 2'b10, 0, 8'd0, 128'd3, 0, 0, '0, 1, 0);
        op("R8 legacy",      2'b00, 2'b10, 1, 8'd5,   '0, 1, 1, 32'h0, 1, 1);
        op("R8 legacy reg",  2'b01, 2'b01, 0, 8'd0,   128'd40, 0, 0, '0, 0, 1);
        idle(4);

        for (int t = 0; t < 600; t++) begin
            logic [127:0] cv;
            logic [7:0] im;
            cv = '0;
            cv[127:64] = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: cv[63:0] = 64'($urandom_range(0, 70));
                1: cv[63:0] = 64'(15 + $urandom_range(0, 2)) + (64'($urandom_range(0, 1)) << 4);
                2: cv[63:0] = 64'(1) << $urandom_range(6, 63);
                default: cv[63:0] = 64'($urandom_range(30, 34));
            endcase
            im = 8'($urandom);
            op("R1 R2 R5 R7 random", 2'($urandom), 2'($urandom), 1'($urandom), im, cv,
               1'($urandom), 1'($urandom), $urandom, 1'($urandom),
               ($urandom_range(0, 7) == 0));
            if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
        end
        idle(3);

        checking = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: run exp complete, got hung");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule